// File: doc/BRIEF.md
# Polled Seeded Random Word Generator

This block is a register-mapped random number peripheral on a simple 32-bit single-cycle bus. Software loads five seed words, then writes a control word that selects the generator engine and requests a start. If every seed slot has been loaded, the block steps a 32-bit Galois LFSR five times and stores one result per step into five output words. Software polls the status word until the done flag appears, then reads the outputs. A start request that does not meet the conditions is dropped without any trace. The start bit always clears itself.

The generator is a two-state machine. In `FS_IDLE` it waits. The transition *accept* (`FS_IDLE` to `FS_FILL`) fires when a control write carries both the engine-select and start bits, all seed slots are loaded, and no run is active. *Accept* loads the LFSR with the XOR of the five seed words, or with a fallback when that XOR is zero. In `FS_FILL`, the transition *advance* (`FS_FILL` to `FS_FILL`) writes one output word per cycle while the word index is below the last slot. The transition *finish* (`FS_FILL` to `FS_IDLE`) writes the last slot and raises the done flag.

Register offsets are bytes, with 32-bit accesses only:

| Offset | Register |
|---|---|
| 0x000 | control |
| 0x010 | status |
| 0x140, 0x144, 0x148, 0x14C, 0x150 | seed slots 0 to 4 |
| 0x160, 0x164, 0x168, 0x16C, 0x170 | output words 0 to 4 |

Read data is registered. `bus_rdata` shows the addressed value in the cycle after the read is accepted, and holds its value when no read is made.

Top module: `rng_poll_ctrl`

## Requirements
- R1: After reset, control reads 0x0, status reads 0x1 (only bit 0, the buffer-ready flag, is set), every output word reads 0, and every seed slot counts as unloaded.
- R2: Status bit 1 (seed ready) is 1 only once each of the five seed slots has been written at least once since reset. Rewriting a slot keeps it at 1.
- R3: A control write starts a run only when control bit 3 (engine select) and bit 4 (start) are both 1 and status bit 1 is 1. Otherwise status and the output words stay unchanged.
- R4: A control write stores all written bits except bit 4, which always reads back as 0.
- R5: An accepted start sets status bit 2 (busy) for exactly five cycles. It then sets status bit 5 (done), so a status read issued in the sixth cycle after the write sees it.
- R6: Output word k holds the LFSR state after k+1 steps. Each step is a right shift, and the mask 0x80200003 is XORed in when the bit shifted out was 1. The start state is the XOR of the five seed words, or 0x00000001 when that XOR is zero.
- R7: A status write updates only bits 5, 4 and 3, each taking the written value. Bit 0 stays 1, and bits 1, 2 and 7 are unaffected.
- R8: Seed slots, misaligned addresses and unmapped offsets read as 0. Writes to unmapped offsets change nothing.
- R9: A control write made while busy is stored, subject to the rule in R4, but does not restart or lengthen the run in progress.
- R10: Output words keep their values between runs. The same seeds always yield the same five words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |

## Verification
The assertions assume that the bus is used for whole-word accesses only. They also assume that software does not clear the done bit in the same cycle the run finishes. The stimulus keeps to this: it writes status only when the block is idle or before a start. It never lets a status write coincide with the final fill cycle. Reset is applied only at a clock boundary, including once in the middle of a run, so the properties are disabled whenever state is cleared.

// File: rtl/rng_poll_pkg.sv
package rng_poll_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,
        FS_FILL = 1'b1
    } fill_state_e;

    // control word fields
    localparam int CTRL_ENG_BIT = 3;
    localparam int CTRL_GO_BIT  = 4;

    // status word fields
    localparam int ST_READY_BIT = 0;
    localparam int ST_SEED_BIT  = 1;
    localparam int ST_BUSY_BIT  = 2;
    localparam int ST_SW_LO     = 3;
    localparam int ST_SW_HI     = 5;
    localparam int ST_DONE_BIT  = 5;
    localparam int ST_ERR_BIT   = 7;

    // one Galois step: shift right, fold mask in when a one leaves
    function automatic logic [WORD_W-1:0] lfsr_step(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] mask
    );
        lfsr_step = {1'b0, cur[WORD_W-1:1]} ^ (cur[0] ? mask : '0);
    endfunction

endpackage

// File: rtl/rng_seed_track.sv
module rng_seed_track
    import rng_poll_pkg::*;
#(
    parameter int N_WORDS = 5,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_val,
    output logic              seed_done,
    output logic [WORD_W-1:0] fold
);

    logic [WORD_W-1:0]  slots [N_WORDS];
    logic [N_WORDS-1:0] loaded;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded <= '0;
            for (int k = 0; k < N_WORDS; k++) slots[k] <= '0;
        end else if (ld_en) begin
            for (int k = 0; k < N_WORDS; k++) begin
                if (ld_idx == IDX_W'(k)) begin
                    slots[k]  <= ld_val;
                    loaded[k] <= 1'b1;
                end
            end
        end
    end

    assign seed_done = &loaded;

    always_comb begin
        fold = '0;
        for (int k = 0; k < N_WORDS; k++) fold = fold ^ slots[k];
    end

    // R2: once every slot is loaded the ready flag never drops
    a_r2_seed_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seed_done |=> seed_done);

endmodule

// File: rtl/rng_fill_fsm.sv
module rng_fill_fsm
    import rng_poll_pkg::*;
#(
    parameter int                N_WORDS  = 5,
    parameter int                IDX_W    = 3,
    parameter logic [WORD_W-1:0] POLY     = 32'h8020_0003,
    parameter logic [WORD_W-1:0] FALLBACK = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] fold,
    output logic              busy,
    output logic              word_we,
    output logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] word_val,
    output logic              fill_done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS - 1);

    fill_state_e       state;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] lfsr;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            idx   <= '0;
            lfsr  <= FALLBACK;
        end else begin
            unique case (state)
                FS_IDLE: begin
                    if (go) begin
                        state <= FS_FILL;
                        idx   <= '0;
                        lfsr  <= (fold == '0) ? FALLBACK : fold;
                    end
                end
                FS_FILL: begin
                    lfsr <= lfsr_step(lfsr, POLY);
                    if (idx == LAST) begin
                        state <= FS_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    // output process
    always_comb begin
        busy      = 1'b0;
        word_we   = 1'b0;
        fill_done = 1'b0;
        word_idx  = idx;
        word_val  = lfsr_step(lfsr, POLY);
        unique case (state)
            FS_IDLE: begin
                busy = 1'b0;
            end
            FS_FILL: begin
                busy      = 1'b1;
                word_we   = 1'b1;
                fill_done = (idx == LAST);
            end
        endcase
    end

    // R5: the fill index never passes the last slot
    a_r5_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= LAST));

    // R5: the last fill cycle returns the machine to idle
    a_r5_finish_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !busy);

    // R6: the shift register never locks up at zero while filling
    a_r6_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lfsr != '0));

endmodule

// File: rtl/rng_out_bank.sv
module rng_out_bank
    import rng_poll_pkg::*;
#(
    parameter int N_WORDS = 5,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_val
);

    logic [WORD_W-1:0] words [N_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_WORDS; k++) words[k] <= '0;
        end else if (we) begin
            for (int k = 0; k < N_WORDS; k++) begin
                if (wr_idx == IDX_W'(k)) words[k] <= wr_val;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (rd_idx == IDX_W'(k)) rd_val = words[k];
        end
    end

endmodule

// File: rtl/rng_poll_ctrl.sv
module rng_poll_ctrl
    import rng_poll_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                N_WORDS  = 5,
    parameter logic [WORD_W-1:0] POLY     = 32'h8020_0003,
    parameter logic [WORD_W-1:0] FALLBACK = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'('h000);
    localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'('h010);
    localparam logic [ADDR_W-1:0] A_SEED     = ADDR_W'('h140);
    localparam logic [ADDR_W-1:0] A_OUT      = ADDR_W'('h160);
    localparam logic [ADDR_W-1:0] A_SEED_END = A_SEED + ADDR_W'(4 * N_WORDS);
    localparam logic [ADDR_W-1:0] A_OUT_END  = A_OUT + ADDR_W'(4 * N_WORDS);

    // address decode
    logic             aligned, hit_ctrl, hit_stat, hit_seed, hit_out;
    logic [IDX_W-1:0] seed_idx, out_idx;

    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        hit_ctrl = (bus_addr == A_CTRL);
        hit_stat = (bus_addr == A_STAT);
        hit_seed = aligned && (bus_addr >= A_SEED) && (bus_addr < A_SEED_END);
        hit_out  = aligned && (bus_addr >= A_OUT) && (bus_addr < A_OUT_END);
        seed_idx = IDX_W'((bus_addr - A_SEED) >> 2);
        out_idx  = IDX_W'((bus_addr - A_OUT) >> 2);
    end

    logic wr_acc, rd_acc, wr_ctrl, wr_stat, wr_seed;
    assign wr_acc  = bus_valid && bus_write;
    assign rd_acc  = bus_valid && !bus_write;
    assign wr_ctrl = wr_acc && hit_ctrl;
    assign wr_stat = wr_acc && hit_stat;
    assign wr_seed = wr_acc && hit_seed;

    // sub-blocks
    logic              seed_done;
    logic [WORD_W-1:0] fold;
    logic              busy, word_we, fill_done;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] word_val, out_rd;
    logic              go;

    rng_seed_track #(.N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_seed (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (wr_seed),
        .ld_idx    (seed_idx),
        .ld_val    (bus_wdata),
        .seed_done (seed_done),
        .fold      (fold)
    );

    assign go = wr_ctrl && bus_wdata[CTRL_ENG_BIT] && bus_wdata[CTRL_GO_BIT]
                && seed_done && !busy;

    rng_fill_fsm #(
        .N_WORDS  (N_WORDS),
        .IDX_W    (IDX_W),
        .POLY     (POLY),
        .FALLBACK (FALLBACK)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .fold      (fold),
        .busy      (busy),
        .word_we   (word_we),
        .word_idx  (word_idx),
        .word_val  (word_val),
        .fill_done (fill_done)
    );

    rng_out_bank #(.N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (word_we),
        .wr_idx (word_idx),
        .wr_val (word_val),
        .rd_idx (out_idx),
        .rd_val (out_rd)
    );

    // control and software-owned status bits
    logic [WORD_W-1:0]          ctrl_q;
    logic [ST_SW_HI:ST_SW_LO]   sw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sw_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q              <= bus_wdata;
                ctrl_q[CTRL_GO_BIT] <= 1'b0;
            end
            if (wr_stat) sw_q <= bus_wdata[ST_SW_HI:ST_SW_LO];
            if (fill_done) sw_q[ST_DONE_BIT] <= 1'b1;
        end
    end

    logic [WORD_W-1:0] status_word;
    always_comb begin
        status_word                        = '0;
        status_word[ST_READY_BIT]          = 1'b1;
        status_word[ST_SEED_BIT]           = seed_done;
        status_word[ST_BUSY_BIT]           = busy;
        status_word[ST_SW_HI:ST_SW_LO]     = sw_q;
        status_word[ST_ERR_BIT]            = 1'b0;
    end

    // read path
    logic [WORD_W-1:0] rd_next;
    always_comb begin
        rd_next = '0;
        if (hit_ctrl)      rd_next = ctrl_q;
        else if (hit_stat) rd_next = status_word;
        else if (hit_out)  rd_next = out_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rd_next;
    end

    // R4: the start bit is never held in the control register
    a_r4_start_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTRL_GO_BIT]);

    // R3: an accepted start is followed by a busy engine
    a_r3_accept_starts_fill: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // R9: a run in progress is never cut short
    a_r9_run_uninterrupted: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fill_done) |=> busy);

    // R7: hardware-owned fixed status bits
    a_r7_fixed_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[ST_READY_BIT] && !status_word[ST_ERR_BIT]);

    // R8: seed slots read back as zero
    a_r8_seed_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && hit_seed) |=> (bus_rdata == '0));

endmodule

// File: tb/test_rng_poll_ctrl.sv
`timescale 1ns/1ps
module test_rng_poll_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    always #4 clk = ~clk;   // 125 MHz

    rng_poll_ctrl i_rng_poll_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;   // write data, or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam int N_VEC = 33;
    localparam vec_t VECS [N_VEC] = '{
        '{1'b0, 12'h000, 32'h0000_0000, 4'd1},   // R1 control
        '{1'b0, 12'h010, 32'h0000_0001, 4'd1},   // R1 status
        '{1'b0, 12'h160, 32'h0000_0000, 4'd1},   // R1 output 0
        '{1'b0, 12'h170, 32'h0000_0000, 4'd1},   // R1 output 4
        '{1'b1, 12'h140, 32'h1234_5678, 4'd2},   // R2 seeds
        '{1'b1, 12'h144, 32'h9ABC_DEF0, 4'd2},
        '{1'b1, 12'h148, 32'h0F0F_0F0F, 4'd2},
        '{1'b1, 12'h14C, 32'hDEAD_BEEF, 4'd2},
        '{1'b0, 12'h010, 32'h0000_0001, 4'd2},   // R2 four of five
        '{1'b1, 12'h000, 32'h0000_0018, 4'd3},   // R3 start without seeds
        '{1'b0, 12'h010, 32'h0000_0001, 4'd3},
        '{1'b0, 12'h000, 32'h0000_0008, 4'd4},   // R4 start bit dropped
        '{1'b1, 12'h150, 32'h0000_0001, 4'd2},
        '{1'b0, 12'h010, 32'h0000_0003, 4'd2},   // R2 all loaded
        '{1'b1, 12'h148, 32'h0F0F_0F0F, 4'd2},
        '{1'b0, 12'h010, 32'h0000_0003, 4'd2},   // R2 rewrite keeps it
        '{1'b0, 12'h140, 32'h0000_0000, 4'd8},   // R8 seed reads zero
        '{1'b1, 12'h1FC, 32'hCAFE_F00D, 4'd8},
        '{1'b0, 12'h1FC, 32'h0000_0000, 4'd8},   // R8 unmapped
        '{1'b0, 12'h204, 32'h0000_0000, 4'd8},   // R8 past window
        '{1'b0, 12'h162, 32'h0000_0000, 4'd8},   // R8 misaligned
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 4'd7},
        '{1'b0, 12'h010, 32'h0000_003B, 4'd7},   // R7 only 5..3 move
        '{1'b1, 12'h010, 32'h0000_0010, 4'd7},
        '{1'b0, 12'h010, 32'h0000_0013, 4'd7},
        '{1'b1, 12'h010, 32'h0000_0000, 4'd7},
        '{1'b0, 12'h010, 32'h0000_0003, 4'd7},
        '{1'b1, 12'h000, 32'h0000_0010, 4'd3},   // R3 no engine select
        '{1'b0, 12'h010, 32'h0000_0003, 4'd3},
        '{1'b0, 12'h160, 32'h0000_0000, 4'd3},
        '{1'b1, 12'h000, 32'hFFFF_FFF7, 4'd4},
        '{1'b0, 12'h000, 32'hFFFF_FFE7, 4'd4},   // R4 other bits kept
        '{1'b0, 12'h010, 32'h0000_0003, 4'd3}
    };

    function automatic logic [31:0] model_step(input logic [31:0] s);
        model_step = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_chk(input logic [11:0] a, input logic [31:0] exp,
                           input int req);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d addr 0x%03h: actual 0x%08h expected 0x%08h",
                     req, a, bus_rdata, exp);
        end
    endtask

    logic [31:0] exp_w [5];
    logic [31:0] seeds [5];

    task automatic build_model();
        logic [31:0] s;
        s = seeds[0] ^ seeds[1] ^ seeds[2] ^ seeds[3] ^ seeds[4];
        if (s == 32'h0) s = 32'h0000_0001;
        for (int k = 0; k < 5; k++) begin
            s = model_step(s);
            exp_w[k] = s;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R7 R8
        for (int v = 0; v < N_VEC; v++) begin
            if (VECS[v].wr) bus_wr(VECS[v].addr, VECS[v].data);
            else            bus_chk(VECS[v].addr, VECS[v].data, int'(VECS[v].req));
        end

        seeds[0] = 32'h1234_5678; seeds[1] = 32'h9ABC_DEF0;
        seeds[2] = 32'h0F0F_0F0F; seeds[3] = 32'hDEAD_BEEF;
        seeds[4] = 32'h0000_0001;
        build_model();

        // R5: busy for five cycles, then done
        bus_wr(12'h000, 32'h0000_0018);
        for (int c = 0; c < 5; c++) bus_chk(12'h010, 32'h0000_0007, 5);
        bus_chk(12'h010, 32'h0000_0023, 5);
        // R6: output words follow the LFSR sequence
        for (int k = 0; k < 5; k++) bus_chk(12'h160 + 12'(4 * k), exp_w[k], 6);

        // R9: second control write while busy neither restarts nor extends
        bus_wr(12'h010, 32'h0);
        bus_wr(12'h000, 32'h0000_0018);
        bus_wr(12'h000, 32'h0000_0018);
        for (int c = 0; c < 4; c++) bus_chk(12'h010, 32'h0000_0007, 9);
        bus_chk(12'h010, 32'h0000_0023, 9);
        bus_chk(12'h000, 32'h0000_0008, 9);
        // R10: same seeds give the same words, held after the run
        repeat (10) @(negedge clk);
        for (int k = 0; k < 5; k++) bus_chk(12'h160 + 12'(4 * k), exp_w[k], 10);

        // R6: zero fold uses the fallback start state
        for (int k = 0; k < 5; k++) begin
            seeds[k] = 32'h0;
            bus_wr(12'h140 + 12'(4 * k), 32'h0);
        end
        build_model();
        bus_wr(12'h010, 32'h0);
        bus_wr(12'h000, 32'h0000_0018);
        repeat (6) @(negedge clk);
        bus_chk(12'h010, 32'h0000_0023, 6);
        for (int k = 0; k < 5; k++) bus_chk(12'h160 + 12'(4 * k), exp_w[k], 6);

        // R1: reset in the middle of a run clears everything
        bus_wr(12'h000, 32'h0000_0018);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_chk(12'h010, 32'h0000_0001, 1);
        bus_chk(12'h000, 32'h0000_0000, 1);
        bus_chk(12'h160, 32'h0000_0000, 1);
        bus_chk(12'h170, 32'h0000_0000, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule